// File: doc/BRIEF.md
# Serial Audio Slot Transmitter

This block serializes up to eight parallel PCM channels onto one serial data line of a shared audio bus. It runs in target mode. An external bit clock and frame sync come in, and the block oversamples them with its own system clock. It finds their edges and launches one data bit after each effective bit-clock falling edge. The frame layout is selected at run time: multichannel TDM, I2S, or left-justified two-half framing.

Each channel carries a 5-bit slot number and an enable. All slots share one word length, which may be 16, 20, 24 or 32 bits. A common offset of 0 to 31 bit clocks delays the first slot after the frame reference. Either incoming clock may be inverted before use. The block raises an output enable only while an enabled channel owns the current slot. Other devices can therefore fill the remaining slots on the same wire. Samples are latched once per frame, so each frame is sent from one coherent set of words.

Top module: `audio_slot_tx`

## Requirements
- R1: After reset, and until the first frame reference, `sd_oe_o` and `sd_o` are both 0.
- R2: In TDM mode (`fmt_i` = 00), the frame reference is the bit-clock rising edge R0 at which the effective frame sync is first sampled high after being low. Stream bit p is launched on the falling edge that follows rising edge R(p+1+offset).
- R3: Stream position p falls in slot p / W at bit p % W, where W is the word length. TDM has slots 0 to 31, and the line is released once slot 31 has been sent.
- R4: The `wlen_i` code sets W: 00 gives 16, 01 gives 20, 10 gives 24, 11 gives 32. Every slot is exactly W bits long.
- R5: In I2S (`fmt_i` = 01), each change of frame sync starts a half with a one-cycle delay. The left half starts when sync falls and the right half when it rises. In left-justified mode (`fmt_i` = 10), the left half starts on a rise and the right half on a fall, with no delay. Slot codes 0 to 15 select left slots 0 to 15, and codes 16 to 31 select right slots 0 to 15.
- R6: `tx_offset_i` delays the first slot of the frame, and of each half, by that many bit clocks.
- R7: `fsync_inv_i` inverts the frame sync and `bclk_inv_i` inverts the bit clock before either is used.
- R8: `sd_oe_o` is 0 during the offset wait, after the last slot, and in any slot that no enabled channel owns. While `sd_oe_o` is 0, `sd_o` is 0.
- R9: When several enabled channels name the same slot, the lowest-numbered one drives it.
- R10: Each word is sent MSB first, using bits 31 down to 32-W of the channel's sample. Samples are latched at the frame reference (TDM rise, I2S left half, left-justified left half). Later input changes affect only the next frame.
- R11: With the reserved code `fmt_i` = 11, no frame reference is taken and `sd_oe_o` stays 0.
- R12: `sd_o` and `sd_oe_o` change only right after an effective bit-clock falling edge. They are stable across the high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus clocks |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk_i | input | 1 | Bus bit clock |
| fsync_i | input | 1 | Bus frame sync |
| fmt_i | input | 2 | Framing: 00 TDM, 01 I2S, 10 left-justified, 11 reserved |
| wlen_i | input | 2 | Word length code |
| tx_offset_i | input | 5 | Slot-start delay in bit clocks |
| fsync_inv_i | input | 1 | Invert frame sync |
| bclk_inv_i | input | 1 | Invert bit clock |
| ch_en_i | input | NUM_CH | Per-channel enable |
| ch_slot_i | input | NUM_CH*5 | Per-channel slot code, channel k in bits [5k+4:5k] |
| ch_data_i | input | NUM_CH*32 | Per-channel sample, channel k in bits [32k+31:32k] |
| sd_o | output | 1 | Serial data |
| sd_oe_o | output | 1 | Data line drive enable |

## Verification
TDM frames are driven at all four word lengths with several slot layouts, including scattered slots, slot 31 and a colliding pair. These separate slot arithmetic from word-length decoding and show the lower-channel priority. I2S and left-justified frames, with and without offset and with both clocks inverted, tell the two half references and their one-cycle difference apart. A frame whose samples change part way through shows that data is latched at frame start. A run in the reserved format confirms that the line stays undriven. At every bit the bench compares both outputs against its own model of the frame, and it also confirms they hold steady through the high phase.

// File: rtl/audio_slot_tx.sv
module audio_slot_tx #(
  parameter int NUM_CH = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bclk_i,
  input  logic                 fsync_i,
  input  logic [1:0]           fmt_i,
  input  logic [1:0]           wlen_i,
  input  logic [4:0]           tx_offset_i,
  input  logic                 fsync_inv_i,
  input  logic                 bclk_inv_i,
  input  logic [NUM_CH-1:0]    ch_en_i,
  input  logic [NUM_CH*5-1:0]  ch_slot_i,
  input  logic [NUM_CH*32-1:0] ch_data_i,
  output logic                 sd_o,
  output logic                 sd_oe_o
);
  localparam int SMP_W = 32;
  localparam int BIT_W = $clog2(SMP_W);
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic b_s, b_d, fs_s, fs_prev;
  logic valid, right_half;
  logic [5:0] wait_cnt;
  logic [4:0] slot_cnt;
  logic [BIT_W-1:0] bit_cnt;
  logic [SMP_W-1:0] shadow [NUM_CH];

  wire rise = b_s & ~b_d;
  wire fall = ~b_s & b_d;
  wire is_tdm = (fmt_i == 2'b00);
  wire is_i2s = (fmt_i == 2'b01);
  wire is_lj  = (fmt_i == 2'b10);
  wire rsv    = (fmt_i == 2'b11);
  wire fs_chg = rise && (fs_s != fs_prev);

  wire tdm_ref  = is_tdm && fs_chg && fs_s;
  wire half_ref = (is_i2s || is_lj) && fs_chg;
  wire any_ref  = tdm_ref || half_ref;
  wire frm_ref  = tdm_ref || (is_i2s && fs_chg && !fs_s) || (is_lj && fs_chg && fs_s);
  wire ref_right = (is_i2s && fs_s) || (is_lj && !fs_s);

  wire [5:0] dly = {5'd0, !is_lj} + {1'b0, tx_offset_i};
  wire [4:0] slot_lim = is_tdm ? 5'd31 : 5'd15;

  logic [BIT_W-1:0] wl_m1;
  always_comb begin
    case (wlen_i)
      2'b00:   wl_m1 = BIT_W'(15);
      2'b01:   wl_m1 = BIT_W'(19);
      2'b10:   wl_m1 = BIT_W'(23);
      default: wl_m1 = BIT_W'(31);
    endcase
  end

  wire [4:0] cur_slot = is_tdm ? slot_cnt : {right_half, slot_cnt[3:0]};

  logic            own_hit;
  logic [CH_W-1:0] own_ch;
  always_comb begin
    own_hit = 1'b0;
    own_ch  = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (ch_en_i[i] && ch_slot_i[i*5 +: 5] == cur_slot) begin
        own_hit = 1'b1;
        own_ch  = CH_W'(i);
      end
    end
  end

  wire [BIT_W-1:0] tap = BIT_W'(SMP_W - 1) - bit_cnt;
  wire cur_bit = shadow[own_ch][tap];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_s <= 1'b0;
      b_d <= 1'b0;
      fs_s <= 1'b0;
    end else begin
      b_s <= bclk_i ^ bclk_inv_i;
      b_d <= b_s;
      fs_s <= fsync_i ^ fsync_inv_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_prev <= 1'b0;
      valid <= 1'b0;
      right_half <= 1'b0;
      wait_cnt <= '0;
      slot_cnt <= '0;
      bit_cnt <= '0;
    end else begin
      if (rise) fs_prev <= fs_s;
      if (rsv) begin
        valid <= 1'b0;
        wait_cnt <= '0;
      end else if (any_ref) begin
        right_half <= ref_right;
        slot_cnt <= '0;
        bit_cnt <= '0;
        valid <= (dly == 6'd0);
        wait_cnt <= dly;
      end else if (rise) begin
        if (wait_cnt > 6'd1) begin
          wait_cnt <= wait_cnt - 6'd1;
        end else if (wait_cnt == 6'd1) begin
          wait_cnt <= '0;
          valid <= 1'b1;
        end else if (valid) begin
          if (bit_cnt >= wl_m1) begin
            bit_cnt <= '0;
            if (slot_cnt == slot_lim) valid <= 1'b0;
            else slot_cnt <= slot_cnt + 5'd1;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
      end
    end
  end

  for (genvar k = 0; k < NUM_CH; k++) begin : g_cap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) shadow[k] <= '0;
      else if (frm_ref) shadow[k] <= ch_data_i[k*SMP_W +: SMP_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sd_o <= 1'b0;
      sd_oe_o <= 1'b0;
    end else if (fall) begin
      sd_oe_o <= valid && own_hit;
      sd_o <= valid && own_hit && cur_bit;
    end
  end

  // R12
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fall |=> ($stable(sd_o) && $stable(sd_oe_o)));

  // R8
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sd_oe_o |-> !sd_o);

  // R3
  bit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !any_ref && !rsv && $stable(wlen_i)) |=> (bit_cnt <= wl_m1 || $changed(wlen_i)));

  // R6
  wait_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_cnt != 6'd0) |-> !valid);

  // R11
  rsv_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsv |=> !valid);
endmodule

// File: tb/audio_slot_tx_tb_top.sv
module audio_slot_tx_tb_top;
  localparam int NCH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bclk = 1'b0, fsync = 1'b0;
  logic [1:0] fmt = 2'b00, wlen = 2'b11;
  logic [4:0] off = 5'd0;
  logic fsi = 1'b0, bci = 1'b0;
  logic [NCH-1:0] en = '0;
  logic [4:0]  slot [NCH];
  logic [31:0] data [NCH];
  logic [31:0] cap  [NCH];
  logic [NCH*5-1:0]  slot_bus;
  logic [NCH*32-1:0] data_bus;
  logic sd, sd_oe;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  always_comb begin
    for (int k = 0; k < NCH; k++) begin
      slot_bus[k*5 +: 5]   = slot[k];
      data_bus[k*32 +: 32] = data[k];
    end
  end

  audio_slot_tx #(.NUM_CH(NCH)) dut_i (
    .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .fsync_i(fsync),
    .fmt_i(fmt), .wlen_i(wlen), .tx_offset_i(off),
    .fsync_inv_i(fsi), .bclk_inv_i(bci), .ch_en_i(en),
    .ch_slot_i(slot_bus), .ch_data_i(data_bus),
    .sd_o(sd), .sd_oe_o(sd_oe)
  );

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run did not complete, got hang expected finish");
    summary();
  end

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int wbits();
    case (wlen)
      2'b00: return 16;
      2'b01: return 20;
      2'b10: return 24;
      default: return 32;
    endcase
  endfunction

  function automatic logic [1:0] expect_out(input int c, input int half);
    int d, p, w, s, b, idx, lim;
    if (fmt == 2'b11) return 2'b00;
    d = (fmt == 2'b10) ? 0 : 1;
    p = c - d - int'(off);
    if (p < 0) return 2'b00;
    w = wbits();
    s = p / w; b = p % w;
    lim = (fmt == 2'b00) ? 32 : 16;
    if (s >= lim) return 2'b00;
    idx = (fmt == 2'b00) ? s : half * 16 + s;
    for (int i = 0; i < NCH; i++)
      if (en[i] && int'(slot[i]) == idx) return {1'b1, cap[i][31-b]};
    return 2'b00;
  endfunction

  task automatic check(input logic [1:0] got, input logic [1:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: {oe,sd} got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic cyc(input logic lvl, input int c, input int half, input bit chk, input string tag);
    logic [1:0] seen;
    fsync = lvl ^ fsi;
    wclk(4);
    seen = {sd_oe, sd};
    if (chk) check(seen, expect_out(c, half), tag);
    bclk = 1'b1 ^ bci;
    wclk(2);
    if (chk) check({sd_oe, sd}, seen, "R12 hold");
    wclk(2);
    bclk = 1'b0 ^ bci;
  endtask

  task automatic run_half(input logic lvl, input int len, input int half, input bit pulse,
                          input int chg_at, input string tag);
    for (int j = 0; j < len; j++) begin
      if (j == chg_at) for (int k = 0; k < NCH; k++) data[k] = ~data[k];
      cyc(pulse ? (j == 0) : lvl, j - 1, half, j >= 1, tag);
    end
  endtask

  task automatic pre(input logic lvl);
    bclk = 1'b0 ^ bci;
    for (int j = 0; j < 3; j++) cyc(lvl, 0, 0, 0, "");
  endtask

  task automatic latch();
    for (int k = 0; k < NCH; k++) cap[k] = data[k];
  endtask

  task automatic tdm_frame(input int len, input int chg_at, input string tag);
    pre(1'b0); latch(); run_half(1'b0, len, 0, 1, chg_at, tag);
  endtask

  task automatic i2s_frame(input int len, input string tag);
    pre(1'b1); latch(); run_half(1'b0, len, 0, 0, -1, tag); run_half(1'b1, len, 1, 0, -1, tag);
  endtask

  task automatic lj_frame(input int len, input string tag);
    pre(1'b0); latch(); run_half(1'b1, len, 0, 0, -1, tag); run_half(1'b0, len, 1, 0, -1, tag);
  endtask

  task automatic setup(input logic [1:0] f, input logic [1:0] w, input logic [4:0] o);
    fmt = f; wlen = w; off = o; fsi = 0; bci = 0; en = '0;
    for (int k = 0; k < NCH; k++) begin
      slot[k] = 5'(k);
      data[k] = 32'h9E37_79B9 * (k + 3) ^ {k[7:0], 24'h5A3C1};
    end
  endtask

  task automatic t_reset();
    wclk(3);
    check({sd_oe, sd}, 2'b00, "R1 reset");
  endtask

  task automatic t_tdm32();
    setup(2'b00, 2'b11, 5'd0);
    en = 8'b0000_1111;
    tdm_frame(5 * 32 + 2, -1, "R2 R3 R4 R8 R10 tdm32");
  endtask

  task automatic t_tdm16_last();
    setup(2'b00, 2'b00, 5'd0);
    en = 8'b0000_0111; slot[0] = 5'd31; slot[1] = 5'd0; slot[2] = 5'd5;
    tdm_frame(32 * 16 + 4, -1, "R3 R4 tdm16 slot31");
  endtask

  task automatic t_tdm20_off();
    setup(2'b00, 2'b01, 5'd7);
    en = 8'b0000_0111; slot[0] = 5'd1; slot[1] = 5'd0; slot[2] = 5'd3;
    tdm_frame(100, -1, "R4 R6 tdm20 offset7");
  endtask

  task automatic t_tdm24_collide();
    setup(2'b00, 2'b10, 5'd31);
    en = 8'b0010_0100; slot[2] = 5'd1; slot[5] = 5'd1; slot[4] = 5'd0;
    tdm_frame(110, -1, "R9 R8 tdm24 collision");
  endtask

  task automatic t_latch();
    setup(2'b00, 2'b11, 5'd0);
    en = 8'b0000_1111;
    tdm_frame(5 * 32 + 2, 40, "R10 frame latch");
  endtask

  task automatic t_i2s();
    setup(2'b01, 2'b00, 5'd0);
    en = 8'b0000_1111; slot[0] = 5'd0; slot[1] = 5'd16; slot[2] = 5'd17; slot[3] = 5'd1;
    i2s_frame(40, "R5 i2s16");
  endtask

  task automatic t_lj();
    setup(2'b10, 2'b10, 5'd3);
    en = 8'b0000_0111; slot[0] = 5'd16; slot[1] = 5'd0; slot[2] = 5'd2;
    lj_frame(60, "R5 R6 lj24 offset3");
  endtask

  task automatic t_invert();
    setup(2'b01, 2'b11, 5'd2);
    fsi = 1; bci = 1;
    en = 8'b0000_0011; slot[0] = 5'd0; slot[1] = 5'd16;
    i2s_frame(70, "R7 i2s inverted");
  endtask

  task automatic t_rsv();
    setup(2'b11, 2'b11, 5'd0);
    en = 8'hFF;
    tdm_frame(80, -1, "R11 reserved");
  endtask

  initial begin
    for (int k = 0; k < NCH; k++) begin slot[k] = '0; data[k] = '0; cap[k] = '0; end
    wclk(4);
    t_reset();
    rst_n = 1'b1;
    wclk(2);
    check({sd_oe, sd}, 2'b00, "R1 idle after reset");
    t_tdm32();
    t_tdm16_last();
    t_tdm20_off();
    t_tdm24_collide();
    t_latch();
    t_i2s();
    t_lj();
    t_invert();
    t_rsv();
    summary();
  end
endmodule